// File: doc/BRIEF.md
# Slave Serial Audio Transmitter

This block takes one stereo sample pair at a time from a recording path and shifts it out on a shared serial audio line. It never generates clocks. The system provides a master clock at 256 times the sample rate, together with a bit clock and a word select. The block samples both of these with the master clock, finds their edges, and drives one data bit per bit clock. It works out its position in the frame from the word-select transitions that it observes.

A 3-bit mode input chooses the framing, the sample width and the bit-clock ratio. The framing is I2S or LSB-justified, the width is 16 or 18 bits, and the ratio is 32 or 64 bit clocks per frame. A separate input chooses which bit-clock edge launches data. An enable input releases the data line to high impedance so that other talkers can use the bus. Samples arrive as parallel left/right words with a one-cycle valid strobe. A pair is held until the next left slot begins, and is then sent left first, right second.

Top module: `serial_audio_tx`

## Requirements
- R1: After reset, and until the first word-select transition has been seen at a capture edge, the data bit is 0.
- R2: Modes 000, 001 and 011 use LSB-justified framing with word select high marking the left slot. The slot is 16 bits at 32 bit clocks per frame or 32 bits at 64. The sample is 16 bits (input bits 15:0) for 000 and 001, and 18 bits (17:0) for 011. The sample is sent MSB first, with its LSB in the last bit before word select changes.
- R3: Modes 100, 101 and 111 use I2S framing with word select low marking the left slot. Slot and sample sizes match the corresponding LSB-justified codes. The MSB is the second bit after a word-select transition, and the following bits come MSB first.
- R4: Every slot bit that carries no sample bit is sent as 0, and input bits above the selected width are ignored.
- R5: A pair accepted on `word_valid` is first sent in the next left slot that starts. If no new pair arrives, the last pair is sent again in each frame.
- R6: With `edge_sel` 0, data changes after falling bit-clock edges. With `edge_sel` 1, data changes after rising edges.
- R7: While `out_en` is low, `sd_oe` is low and `sd_out` is high impedance. Framing continues, and correct data reappears as soon as `out_en` returns high.
- R8: Mode codes 010 and 110 are not supported, and the data bit stays 0 in them.
- R9: The data bit changes only in response to a launch edge, and no later than SYNC_STAGES+1 master clocks after that edge arrives at the pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock, 256 x sample rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 3 | Framing / width / ratio code |
| edge_sel | input | 1 | Launch edge select: 0 falling, 1 rising |
| out_en | input | 1 | Drive enable for the data line |
| bck_in | input | 1 | Bit clock from the system |
| ws_in | input | 1 | Word select from the system |
| left_word | input | SAMPLE_W | Left sample |
| right_word | input | SAMPLE_W | Right sample |
| word_valid | input | 1 | One-cycle strobe accepting the pair |
| sd_out | output | 1 | Serial data, high impedance when disabled |
| sd_oe | output | 1 | High while the block drives `sd_out` |

## Verification
The hardest situations to reach from the ports are the frame boundary of I2S and the swap from one pair to the next. In I2S, the first bit after a word-select change still belongs to the previous channel's word. When a new pair arrives, that same boundary bit must still come from the old right sample. The bench drives the bit clock and word select itself and runs four consecutive frames after lock. It loads a new pair between the second and third frames, so the third frame's opening bit must carry the old right LSB slot while everything after it carries the new pair. Each of the six legal modes is swept with both launch edges.

// File: rtl/sat_pkg.sv
package sat_pkg;
   localparam int SLOT_SHORT = 16;
   localparam int SLOT_LONG  = 32;
   localparam int WORD_SHORT = 16;
   localparam int WORD_LONG  = 18;
   localparam int IDX_W      = $clog2(SLOT_LONG);

   typedef enum logic {FRAME_RJ = 1'b0, FRAME_I2S = 1'b1} frame_e;

   typedef struct packed {
      logic   legal;
      frame_e framing;
      logic   long_slot;
      logic   long_word;
   } fmt_cfg_t;

   // mode[2] picks framing, mode[0] picks 64 bit clocks per frame,
   // mode[1]&mode[0] picks 18-bit samples, mode[1]&~mode[0] is unsupported
   function automatic fmt_cfg_t decode_mode(input logic [2:0] m);
      fmt_cfg_t c;
      c.framing   = m[2] ? FRAME_I2S : FRAME_RJ;
      c.long_slot = m[0];
      c.long_word = m[1] & m[0];
      c.legal     = ~(m[1] & ~m[0]);
      return c;
   endfunction
endpackage

// File: rtl/sat_sync.sv
module sat_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] chain;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[i] <= 1'b0;
            else        chain[i] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[i] <= 1'b0;
            else        chain[i] <= chain[i-1];
         end
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/sat_frame_track.sv
module sat_frame_track #(
   parameter int IDX_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bck_s,
   input  logic             ws_s,
   input  logic             edge_sel,
   input  logic [IDX_W-1:0] slot_last,
   output logic             launch,
   output logic             locked,
   output logic [IDX_W-1:0] nxt_idx,
   output logic             nxt_ws
);
   logic             bck_d;
   logic             rise, fall, capture;
   logic             seen;
   logic             cws;
   logic [IDX_W-1:0] cidx;
   logic             at_end;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) bck_d <= 1'b0;
      else        bck_d <= bck_s;
   end

   assign rise    = bck_s & ~bck_d;
   assign fall    = ~bck_s & bck_d;
   assign launch  = edge_sel ? rise : fall;
   assign capture = edge_sel ? fall : rise;

   // word select is only looked at on capture edges, where it is stable
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seen   <= 1'b0;
         locked <= 1'b0;
         cws    <= 1'b0;
         cidx   <= '0;
      end else if (capture) begin
         if (!seen) begin
            seen <= 1'b1;
            cws  <= ws_s;
         end else if (ws_s != cws) begin
            cws    <= ws_s;
            cidx   <= '0;
            locked <= 1'b1;
         end else begin
            cidx <= (cidx >= slot_last) ? '0 : cidx + 1'b1;
         end
      end
   end

   // predict the capture that follows the next launch edge
   assign at_end  = (cidx >= slot_last);
   assign nxt_idx = at_end ? '0 : cidx + 1'b1;
   assign nxt_ws  = at_end ? ~cws : cws;

   assert_index_in_slot_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (capture && locked) |=> (cidx <= slot_last));
endmodule

// File: rtl/sat_bit_pick.sv
module sat_bit_pick
   import sat_pkg::*;
#(
   parameter int SAMPLE_W = 18,
   parameter int IDX_W    = 5
) (
   input  logic                clk,
   input  logic                rst_n,
   input  fmt_cfg_t            cfg,
   input  logic                launch,
   input  logic                locked,
   input  logic [IDX_W-1:0]    nxt_idx,
   input  logic                nxt_ws,
   input  logic [SAMPLE_W-1:0] left_word,
   input  logic [SAMPLE_W-1:0] right_word,
   input  logic                word_valid,
   output logic                sd_q
);
   localparam int CW = IDX_W + 1;

   logic [SAMPLE_W-1:0] stage_l, stage_r, act_l, act_r, src;
   logic [CW-1:0]       slot_len, word_len, pos, bidx;
   logic                is_i2s, is_left, from_left, in_word, copy, bit_nx;

   always_comb begin
      slot_len  = cfg.long_slot ? CW'(SLOT_LONG) : CW'(SLOT_SHORT);
      word_len  = cfg.long_word ? CW'(WORD_LONG) : CW'(WORD_SHORT);
      is_i2s    = (cfg.framing == FRAME_I2S);
      is_left   = is_i2s ? ~nxt_ws : nxt_ws;
      from_left = is_left;
      pos       = {1'b0, nxt_idx};
      in_word   = 1'b0;
      bidx      = '0;
      if (is_i2s) begin
         // first capture after a change still carries the previous slot's last bit
         if (nxt_idx == '0) begin
            from_left = ~is_left;
            pos       = slot_len - 1'b1;
         end else begin
            pos = {1'b0, nxt_idx} - 1'b1;
         end
         in_word = (pos < word_len);
         bidx    = word_len - 1'b1 - pos;
      end else begin
         in_word = (pos >= slot_len - word_len);
         bidx    = slot_len - 1'b1 - pos;
      end
      copy   = launch & locked & is_left &
               (is_i2s ? (nxt_idx == IDX_W'(1)) : (nxt_idx == '0));
      src    = from_left ? (copy ? stage_l : act_l) : (copy ? stage_r : act_r);
      bit_nx = cfg.legal & locked & in_word & src[bidx];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stage_l <= '0;
         stage_r <= '0;
         act_l   <= '0;
         act_r   <= '0;
         sd_q    <= 1'b0;
      end else begin
         if (word_valid) begin
            stage_l <= left_word;
            stage_r <= right_word;
         end
         if (copy) begin
            act_l <= stage_l;
            act_r <= stage_r;
         end
         if (launch) sd_q <= bit_nx;
      end
   end

   assert_quiet_before_lock_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !locked |=> !sd_q);

   assert_unsupported_mode_silent_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg.legal && launch) |=> !sd_q);

   assert_change_only_on_launch_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sd_q) |-> $past(launch));
endmodule

// File: rtl/serial_audio_tx.sv
module serial_audio_tx
   import sat_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int SAMPLE_W    = 18
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [2:0]          mode,
   input  logic                edge_sel,
   input  logic                out_en,
   input  logic                bck_in,
   input  logic                ws_in,
   input  logic [SAMPLE_W-1:0] left_word,
   input  logic [SAMPLE_W-1:0] right_word,
   input  logic                word_valid,
   output wire                 sd_out,
   output wire                 sd_oe
);
   initial begin
      assert (SYNC_STAGES >= 2) else $error("SYNC_STAGES must be at least 2");
      assert (SAMPLE_W == WORD_LONG) else $error("SAMPLE_W must equal the longest sample width");
   end

   fmt_cfg_t         cfg;
   logic             bck_s, ws_s, launch, locked, nxt_ws, sd_q;
   logic [IDX_W-1:0] nxt_idx, slot_last;

   assign cfg       = decode_mode(mode);
   assign slot_last = cfg.long_slot ? IDX_W'(SLOT_LONG - 1) : IDX_W'(SLOT_SHORT - 1);

   sat_sync #(.STAGES(SYNC_STAGES)) u_sync_bck (
      .clk(clk), .rst_n(rst_n), .d(bck_in), .q(bck_s));
   sat_sync #(.STAGES(SYNC_STAGES)) u_sync_ws (
      .clk(clk), .rst_n(rst_n), .d(ws_in), .q(ws_s));

   sat_frame_track #(.IDX_W(IDX_W)) u_track (
      .clk(clk), .rst_n(rst_n), .bck_s(bck_s), .ws_s(ws_s), .edge_sel(edge_sel),
      .slot_last(slot_last), .launch(launch), .locked(locked),
      .nxt_idx(nxt_idx), .nxt_ws(nxt_ws));

   sat_bit_pick #(.SAMPLE_W(SAMPLE_W), .IDX_W(IDX_W)) u_pick (
      .clk(clk), .rst_n(rst_n), .cfg(cfg), .launch(launch), .locked(locked),
      .nxt_idx(nxt_idx), .nxt_ws(nxt_ws), .left_word(left_word),
      .right_word(right_word), .word_valid(word_valid), .sd_q(sd_q));

   assign sd_oe  = out_en;
   assign sd_out = out_en ? sd_q : 1'bz;
endmodule

// File: tb/sim_serial_audio_tx.sv
module sim_serial_audio_tx;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  mode = 3'b000;
   logic        edge_sel = 1'b0;
   logic        out_en = 1'b1;
   logic        bck_in = 1'b1;
   logic        ws_in = 1'b0;
   logic [17:0] left_word = '0;
   logic [17:0] right_word = '0;
   logic        word_valid = 1'b0;
   wire         sd_out;
   wire         sd_oe;

   int n_run = 0;
   int n_bad = 0;
   bit done = 1'b0;
   int cur_s, cur_w, cur_hp;
   bit cur_i2s, cur_legal;

   always #5 clk = ~clk;

   serial_audio_tx u0 (
      .clk(clk), .rst_n(rst_n), .mode(mode), .edge_sel(edge_sel), .out_en(out_en),
      .bck_in(bck_in), .ws_in(ws_in), .left_word(left_word), .right_word(right_word),
      .word_valid(word_valid), .sd_out(sd_out), .sd_oe(sd_oe));

   task automatic check(input string tag, input logic act, input logic exp);
      n_run++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %b expected %b", tag, act, exp);
      end
   endtask

   // one bit period: launch edge (with word select), then capture edge
   task automatic run_bit(input logic wsv, input logic e, input bit chk, input string tag);
      bck_in = edge_sel;
      ws_in  = wsv;
      repeat (cur_hp) @(negedge clk);
      if (chk && cur_hp == 4 && out_en) check({tag, " R9 settle"}, sd_out, e);
      bck_in = ~edge_sel;
      repeat (cur_hp) @(negedge clk);
      if (chk) begin
         if (out_en) check(tag, sd_out, e);
         else        check({tag, " R7 oe"}, sd_oe, 1'b0);
      end
   endtask

   task automatic run_frame(input logic [17:0] l, input logic [17:0] r,
                            input logic [17:0] prev_r, input bit chk, input string base);
      for (int h = 0; h < 2; h++) begin
         for (int q = 0; q < cur_s; q++) begin
            bit          lf, inw;
            logic        wsv, e;
            logic [17:0] wd;
            int          j, bi;
            string       tag;
            lf  = (h == 0);
            wsv = cur_i2s ? ~lf : lf;
            if (cur_i2s) begin
               if (q == 0) begin wd = lf ? prev_r : l; j = cur_s - 1; end
               else        begin wd = lf ? l : r;      j = q - 1;     end
               inw = (j < cur_w);
               bi  = cur_w - 1 - j;
            end else begin
               wd  = lf ? l : r;
               j   = q;
               inw = (j >= cur_s - cur_w);
               bi  = cur_s - 1 - j;
            end
            e   = (cur_legal && inw) ? wd[bi] : 1'b0;
            tag = !cur_legal ? "R8" : (!inw ? "R4" : (cur_i2s ? "R3" : "R2"));
            run_bit(wsv, e, chk, $sformatf("%s %s mode=%0d edge=%0d R6 h=%0d q=%0d",
                                           base, tag, mode, edge_sel, h, q));
         end
      end
   endtask

   task automatic load_pair(input logic [17:0] l, input logic [17:0] r);
      left_word  = l;
      right_word = r;
      word_valid = 1'b1;
      @(negedge clk);
      word_valid = 1'b0;
   endtask

   task automatic run_config(input logic [2:0] m, input logic e, input int c, input bit with_oe);
      logic [17:0] al, ar, bl, br;
      mode      = m;
      edge_sel  = e;
      out_en    = 1'b1;
      cur_s     = m[0] ? 32 : 16;
      cur_w     = (m[1] & m[0]) ? 18 : 16;
      cur_i2s   = m[2];
      cur_legal = !(m[1] && !m[0]);
      cur_hp    = (cur_s == 32) ? 2 : 4;
      al = 18'h2A5C3 ^ 18'(c * 37);
      ar = 18'h3C96E ^ 18'(c * 91);
      bl = 18'h1F0F1 ^ 18'(c * 13);
      br = 18'h30A6D ^ 18'(c * 59);
      bck_in = ~e;
      ws_in  = cur_i2s ? 1'b1 : 1'b0;
      rst_n  = 1'b0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      check("R1 reset value", sd_out, 1'b0);
      load_pair(al, ar);
      for (int q = 0; q < cur_s; q++) run_bit(ws_in, 1'b0, 1'b1, "R1 before lock");
      run_frame(al, ar, 18'h0, 1'b0, "lock");
      run_frame(al, ar, ar, 1'b1, "R5 first pair");
      load_pair(bl, br);
      run_frame(bl, br, ar, 1'b1, "R5 new pair");
      run_frame(bl, br, br, 1'b1, "R5 held pair");
      if (with_oe) begin
         out_en = 1'b0;
         run_frame(bl, br, br, 1'b1, "R7 disabled");
         out_en = 1'b1;
         run_frame(bl, br, br, 1'b1, "R7 resumed");
      end
   endtask

   initial begin
      int c;
      c = 0;
      for (int m = 0; m < 8; m++) begin
         for (int e = 0; e < 2; e++) begin
            bit ok;
            ok = !(m[1] && !m[0]);
            if (ok || e == 0) begin
               run_config(3'(m), 1'(e), c, (m == 5) || (m == 3));
               c++;
            end
         end
      end
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_run++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
         $finish;
      end
   end
endmodule